// File: doc/BRIEF.md
# Reader Command Character Serializer

This block turns a reader-to-card command into the bit stream a serial transmitter sends. The command arrives one byte at a time over a valid/ready handshake. The stream is built in a fixed order:

1. An opening delimiter.
2. Each byte, wrapped in start-stop character framing.
3. A closing delimiter.
4. A run of fill ones.

The bits are grouped into words of `WORD_W` bits, which is 8 by default. Each word is inverted bit by bit. The words leave on a valid/ready output port, ready for the downstream serial transmitter.

A one-cycle start pulse launches a frame. The byte count is latched at that pulse. The block then requests exactly that many bytes and streams the words out. When the transmitter has taken the final word, the block pulses `done_o` and returns to idle. Checksum generation and modulation are done elsewhere.

Top module: `reader_frame_serializer`

## Requirements
- R1: After reset, `word_valid_o`, `byte_ready_o`, `busy_o` and `done_o` are all 0.
- R2: Every frame begins with ten 0 bits and then two 1 bits, with no preceding run of ones.
- R3: Each byte is framed as one 0 bit, then its eight data bits with bit 0 first, then one 1 bit.
- R4: After the last byte's character, the stream carries ten 0 bits followed by a single 1 bit.
- R5: After that 1 bit come eight 1 bits. Further 1 bits follow until the stream length is a whole number of words, so the frame holds ceil((31+10N)/8) words for N bytes.
- R6: Stream bits fill each word from its most significant bit downward. The word on `word_data_o` is the bitwise inverse of those bits.
- R7: While `word_valid_o` is 1 and `word_ready_i` is 0, the word stays valid and `word_data_o` does not change.
- R8: `byte_ready_o` is 1 only while the block waits for the next byte. Exactly N bytes are taken per frame, in arrival order.
- R9: A start pulse while `busy_o` is 1 is ignored. The stream in flight is unchanged, and no further frame follows it.
- R10: `done_o` is 1 for exactly one cycle: the cycle after the final word is accepted. `busy_o` is 0 in that same cycle.
- R11: `nbytes_i` is sampled only on an accepted start and must be in the range 1 to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a frame (accepted only when idle) |
| nbytes_i | input | 7 | Byte count for the frame, 1 to 64 |
| byte_valid_i | input | 1 | Command byte is valid |
| byte_data_i | input | 8 | Command byte |
| byte_ready_o | output | 1 | Block takes the byte this cycle if valid |
| word_valid_o | output | 1 | Packed, inverted word is valid |
| word_data_o | output | 8 | Packed, inverted word |
| word_ready_i | input | 1 | Transmitter accepts the word |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the inputs:

- `nbytes_i` lies between 1 and 64 whenever a start is accepted.
- `byte_data_i` is not consulted except in a cycle where both `byte_valid_i` and `byte_ready_o` are 1.
- The transmitter may stall for any number of cycles.

The stimulus stays within these limits:

- Every accepted start carries a legal count. The only out-of-band start is one issued mid-frame, which the block must ignore.
- Byte gaps and word-ready stalls are drawn from a random source.
- The start of each frame is spaced until the previous frame has finished.

The reference model rebuilds the expected word list from the bytes alone. It checks every accepted word in order, and it checks the exact cycle of the completion pulse.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_LOAD,
    ST_CHAR,
    ST_EOF,
    ST_FILL,
    ST_DRAIN
  } seq_state_t;

  localparam int SOF_ZEROS = 10;
  localparam int SOF_ONES  = 2;
  localparam int CHAR_BITS = 10;
  localparam int EOF_ZEROS = 10;
  localparam int FILL_ONES = 8;

endpackage

// File: rtl/rfs_word_packer.sv
module rfs_word_packer #(
  parameter int WORD_W = 8,
  localparam int PH_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic              bit_ready_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  input  logic              word_ready_i,
  output logic [PH_W-1:0]   fill_o
);

  logic [WORD_W-2:0] sh_q;
  logic [PH_W-1:0]   fill_q;
  logic              last_slot;
  logic              take_bit;

  assign last_slot   = (fill_q == PH_W'(WORD_W - 1));
  assign bit_ready_o = !(last_slot && word_valid_o && !word_ready_i);
  assign take_bit    = bit_valid_i && bit_ready_o;
  assign fill_o      = fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q         <= '0;
      fill_q       <= '0;
      word_valid_o <= 1'b0;
      word_data_o  <= '0;
    end else begin
      if (word_valid_o && word_ready_i) begin
        word_valid_o <= 1'b0;
      end
      if (take_bit) begin
        fill_q <= fill_q + PH_W'(1);
        if (last_slot) begin
          word_data_o  <= ~{sh_q, bit_i};
          word_valid_o <= 1'b1;
        end else begin
          sh_q <= {sh_q[WORD_W-3:0], bit_i};
        end
      end
    end
  end

  // R7: a stalled word is held unchanged
  p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
    (word_valid_o && !word_ready_i) |=> (word_valid_o && $stable(word_data_o)));

endmodule

// File: rtl/rfs_bit_sequencer.sv
module rfs_bit_sequencer
  import rfs_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int WORD_W    = 8,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int PH_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_ready_o,
  output logic             bit_valid_o,
  output logic             bit_o,
  input  logic             bit_ready_i,
  input  logic             word_accept_i,
  output logic             busy_o,
  output logic             drain_o,
  output logic             done_o
);

  localparam logic [3:0] SOF_LAST  = 4'(SOF_ZEROS + SOF_ONES - 1);
  localparam logic [3:0] SOF_Z     = 4'(SOF_ZEROS);
  localparam logic [3:0] CHAR_LAST = 4'(CHAR_BITS - 1);
  localparam logic [3:0] EOF_LAST  = 4'(EOF_ZEROS);
  localparam logic [3:0] EOF_Z     = 4'(EOF_ZEROS);
  localparam logic [3:0] FILL_LAST = 4'(FILL_ONES - 1);

  seq_state_t       state;
  logic [3:0]       cnt;
  logic [CNT_W-1:0] rem;
  logic [7:0]       data_q;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  phase_n;
  logic [3:0]       didx;
  logic             fire;

  assign didx         = cnt - 4'd1;
  assign phase_n      = phase + PH_W'(1);
  assign byte_ready_o = (state == ST_LOAD);
  assign busy_o       = (state != ST_IDLE);
  assign drain_o      = (state == ST_DRAIN);
  assign bit_valid_o  = (state == ST_SOF) || (state == ST_CHAR) ||
                        (state == ST_EOF) || (state == ST_FILL);
  assign fire         = bit_valid_o && bit_ready_i;

  always_comb begin
    case (state)
      ST_SOF:  bit_o = (cnt >= SOF_Z);
      ST_CHAR: begin
        if (cnt == 4'd0)           bit_o = 1'b0;
        else if (cnt == CHAR_LAST) bit_o = 1'b1;
        else                       bit_o = data_q[didx[2:0]];
      end
      ST_EOF:  bit_o = (cnt >= EOF_Z);
      ST_FILL: bit_o = 1'b1;
      default: bit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      rem    <= '0;
      data_q <= '0;
      phase  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            rem   <= nbytes_i;
            cnt   <= '0;
            phase <= '0;
            state <= ST_SOF;
          end
        end
        ST_SOF: begin
          if (fire) begin
            phase <= phase_n;
            if (cnt == SOF_LAST) begin
              cnt   <= '0;
              state <= ST_LOAD;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
        end
        ST_LOAD: begin
          if (byte_valid_i) begin
            data_q <= byte_data_i;
            cnt    <= '0;
            state  <= ST_CHAR;
          end
        end
        ST_CHAR: begin
          if (fire) begin
            phase <= phase_n;
            if (cnt == CHAR_LAST) begin
              cnt   <= '0;
              rem   <= rem - CNT_W'(1);
              state <= (rem == CNT_W'(1)) ? ST_EOF : ST_LOAD;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
        end
        ST_EOF: begin
          if (fire) begin
            phase <= phase_n;
            if (cnt == EOF_LAST) begin
              cnt   <= '0;
              state <= ST_FILL;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
        end
        ST_FILL: begin
          if (fire) begin
            phase <= phase_n;
            if (cnt >= FILL_LAST && phase_n == '0) begin
              state <= ST_DRAIN;
            end else if (cnt < FILL_LAST) begin
              cnt <= cnt + 4'd1;
            end
          end
        end
        ST_DRAIN: begin
          if (word_accept_i) begin
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: without a byte the sequencer keeps waiting
  p_wait_byte_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && !byte_valid_i) |=> (state == ST_LOAD));

  // R9: a start during a frame never restarts the opening delimiter
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_SOF && start_i) |=> (state != ST_SOF));

endmodule

// File: rtl/reader_frame_serializer.sv
module reader_frame_serializer #(
  parameter int MAX_BYTES = 64,
  parameter int WORD_W    = 8,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int PH_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  input  logic              word_ready_i,
  output logic              busy_o,
  output logic              done_o
);

  logic            bit_valid;
  logic            bit_val;
  logic            bit_ready;
  logic            drain;
  logic [PH_W-1:0] fill;

  rfs_bit_sequencer #(
    .MAX_BYTES(MAX_BYTES),
    .WORD_W   (WORD_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .nbytes_i     (nbytes_i),
    .byte_valid_i (byte_valid_i),
    .byte_data_i  (byte_data_i),
    .byte_ready_o (byte_ready_o),
    .bit_valid_o  (bit_valid),
    .bit_o        (bit_val),
    .bit_ready_i  (bit_ready),
    .word_accept_i(word_valid_o && word_ready_i),
    .busy_o       (busy_o),
    .drain_o      (drain),
    .done_o       (done_o)
  );

  rfs_word_packer #(
    .WORD_W(WORD_W)
  ) u_pack (
    .clk         (clk),
    .rst         (rst),
    .bit_valid_i (bit_valid),
    .bit_i       (bit_val),
    .bit_ready_o (bit_ready),
    .word_valid_o(word_valid_o),
    .word_data_o (word_data_o),
    .word_ready_i(word_ready_i),
    .fill_o      (fill)
  );

  // R5: padding leaves the packer on a word boundary before completion
  p_drain_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    drain |-> (fill == '0 && word_valid_o));

  // R10: completion is a single-cycle pulse seen only when idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R11: accepted byte counts are within range
  p_count_range_r11: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |-> (nbytes_i != '0 && nbytes_i <= CNT_W'(MAX_BYTES)));

endmodule

// File: tb/reader_frame_serializer_tb.sv
module reader_frame_serializer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [6:0] nbytes_i = '0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_data_i = '0;
  logic       byte_ready_o;
  logic       word_valid_o;
  logic [7:0] word_data_o;
  logic       word_ready_i = 1'b0;
  logic       busy_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] src_q[$];
  logic [7:0] exp_q[$];
  bit byte_take = 0;
  bit done_due = 0;
  bit frame_end = 0;
  bit bp_en = 0;
  bit gap_en = 0;
  bit run_on = 0;

  always #2 clk = ~clk;

  reader_frame_serializer u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .nbytes_i(nbytes_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o),
    .word_valid_o(word_valid_o), .word_data_o(word_data_o), .word_ready_i(word_ready_i),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference model: expected word list from the command bytes
  task automatic build_expected(input logic [7:0] b[$]);
    bit bits[$];
    logic [7:0] w;
    for (int i = 0; i < 10; i++) bits.push_back(1'b0);      // R2
    bits.push_back(1'b1); bits.push_back(1'b1);
    foreach (b[k]) begin                                     // R3
      bits.push_back(1'b0);
      for (int i = 0; i < 8; i++) bits.push_back(b[k][i]);
      bits.push_back(1'b1);
    end
    for (int i = 0; i < 10; i++) bits.push_back(1'b0);      // R4
    bits.push_back(1'b1);
    for (int i = 0; i < 8; i++) bits.push_back(1'b1);       // R5
    while (bits.size() % 8 != 0) bits.push_back(1'b1);
    for (int k = 0; k < bits.size(); k += 8) begin           // R6
      for (int i = 0; i < 8; i++) w[7-i] = bits[k+i];
      exp_q.push_back(~w);
    end
  endtask

  // Monitor: samples away from the active edge
  always @(negedge clk) begin
    if (!rst && run_on) begin
      if (done_due) begin
        check(done_o == 1'b1 && busy_o == 1'b0, "R10 done pulse", {done_o, busy_o}, 2'b10);
        done_due = 0;
        frame_end = 1;
      end else if (done_o) begin
        check(1'b0, "R10 unexpected done", 1, 0);
      end
      byte_take = byte_valid_i && byte_ready_o;
      if (word_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 extra word", word_data_o, 0);
        end else if (word_ready_i) begin
          check(word_data_o == exp_q[0], "R2 R3 R4 R5 R6 stream word", word_data_o, exp_q[0]);
          void'(exp_q.pop_front());
          if (exp_q.size() == 0) done_due = 1;
        end
      end
    end
  end

  // Driver: updates inputs just after the edge
  always @(posedge clk) begin
    #1;
    if (byte_take) begin
      void'(src_q.pop_front());
      byte_take = 0;
    end
    byte_valid_i = (src_q.size() > 0) && (!gap_en || ($urandom % 4 != 0));
    byte_data_i  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    word_ready_i = !bp_en || ($urandom % 3 != 0);
  end

  task automatic run_frame(input int n, input int mode, input bit bp, input bit gap, input bit mid_start);
    logic [7:0] b[$];
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: b.push_back(8'h00);
        1: b.push_back((i == 0) ? 8'hA5 : (i == 1) ? 8'hFF : 8'h01);
        2: b.push_back(8'($urandom));
        default: b.push_back(8'(i * 7 + 3));
      endcase
    end
    build_expected(b);
    check(exp_q.size() == (31 + 10*n + 7) / 8, "R5 word count", exp_q.size(), (31 + 10*n + 7) / 8);
    src_q = b;
    bp_en = bp; gap_en = gap; frame_end = 0;
    @(posedge clk); #1;
    start_i = 1'b1; nbytes_i = 7'(n);
    @(posedge clk); #1;
    start_i = 1'b0;
    if (mid_start) begin
      repeat (30) @(posedge clk);
      #1; start_i = 1'b1; nbytes_i = 7'd3;
      @(posedge clk); #1; start_i = 1'b0;
    end
    while (!frame_end) @(negedge clk);
    check(src_q.size() == 0 && byte_ready_o == 1'b0, "R8 bytes consumed", src_q.size(), 0);
    check(exp_q.size() == 0, "R11 latched count words", exp_q.size(), 0);
    if (mid_start) begin
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (busy_o || word_valid_o) begin
          check(1'b0, "R9 ignored start", {busy_o, word_valid_o}, 0);
          break;
        end
      end
      check(busy_o == 1'b0, "R9 ignored start idle", busy_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!word_valid_o && !byte_ready_o && !busy_o && !done_o, "R1 reset state",
          {word_valid_o, byte_ready_o, busy_o, done_o}, 0);
    run_on = 1;
    run_frame(1, 0, 0, 0, 0);
    run_frame(3, 1, 0, 0, 0);
    run_frame(64, 2, 1, 1, 0);
    run_frame(5, 3, 1, 0, 1);
    run_frame(2, 2, 0, 1, 0);
    run_frame(7, 2, 1, 1, 0);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule